// File: doc/BRIEF.md
# GPIO Peripheral Register Bank

This block is a bus-addressed general-purpose I/O peripheral for up to 32 pins. Software reaches it through a simple register read/write port, at fixed byte offsets from the peripheral's base. Through those offsets it sets each pin's drive direction and output level. It can also raise or drop chosen output bits with single write-one-to-act stores. These stores need no read-modify-write, so a concurrent writer cannot lose an update. Software reads back the synchronised pin levels, and it picks, for each of the low pins, which internal source drives the pad.

The bank has a gate input that holds it in a dead, cleared state. While the gate is held, and for a short warm-up after release, every register write is dropped. A ready flag tells software when the bank has woken up, and software polls it before configuring pins. On the pin side, the block gives each pin an output value, an output enable and a synchronised input.

Top module: `gpio_regbank`

## Requirements
- R1: While `bank_hold` is 1, the direction (0x00), level (0x04) and source-select (0x18) registers read 0, bit 0 of the ready word (0x14) reads 0, and every `pad_oe` bit is 0.
- R2: After `bank_hold` falls, bit 0 at offset 0x14 reads 0 for the first READY_DLY-1 rising clock edges and reads 1 from edge READY_DLY onward (default 4).
- R3: A write is ignored while `bank_hold` is 1 or while the ready flag is still 0.
- R4: Offset 0x00 is the direction register. It is readable and writable, and bit k set to 1 makes `pad_oe[k]` 1.
- R5: Offset 0x04 is the output level register. It is readable and writable, and bit k reaches `pad_out[k]` when pin k is an output using the software source.
- R6: A write to offset 0x08 sets each level bit whose data bit is 1 and leaves the other level bits unchanged. Offset 0x08 reads 0.
- R7: A write to offset 0x0C clears each level bit whose data bit is 1 and leaves the other level bits unchanged. Offset 0x0C reads 0.
- R8: When direction bit k is 0, `pad_oe[k]` is 0 and `pad_out[k]` is 0, whatever the level bit holds.
- R9: Offset 0x18 holds a 2-bit source code for each pin k below 16, in bits [2k+1:2k], with reset value 0. Code 00 drives the pad from `ser_tx_i[k]`, code 01 from `pwm_i[k]`, and codes 10 and 11 from the level register. Pins 16 and above always use the level register.
- R10: Offset 0x10 returns `pad_in` through two flip-flops, so a change shows after two rising edges and not after one. Writes to 0x10 change nothing.
- R11: Raising `bank_hold` again clears the direction, level and source-select registers and drops the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bank_hold | input | 1 | Holds the peripheral in its cleared, deaf state while 1 |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset from the peripheral base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ser_tx_i | input | 16 | Serial transmit source, one bit per selectable pin |
| pwm_i | input | 16 | PWM source, one bit per selectable pin |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin (0 = high impedance) |

## Verification
The embedded assertions check several rules on every cycle. The ready flag stays low while the gate is held, stays high once up, and rises only after a gate-free cycle. Holding the gate clears the registers and the output enables. A cycle with no accepted write leaves direction and level unchanged. The set and clear aliases change exactly the named bits. The directed scenarios show what a property cannot: the exact warm-up length seen through the bus, the per-pin source routing under mixed select codes, the two-edge input latency, and the read-as-zero and write-ignored offsets.

// File: rtl/gpiobank_pkg.sv
package gpiobank_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFS_DIR   = 8'h00;
  localparam logic [7:0] OFS_LVL   = 8'h04;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;
  localparam logic [7:0] OFS_SENSE = 8'h10;
  localparam logic [7:0] OFS_READY = 8'h14;
  localparam logic [7:0] OFS_SRC   = 8'h18;

  typedef enum logic [1:0] {
    SRC_SER = 2'b00,
    SRC_PWM = 2'b01,
    SRC_SW  = 2'b10,
    SRC_SW2 = 2'b11
  } pin_src_e;

  typedef enum logic [1:0] {
    LVL_KEEP = 2'b00,
    LVL_LOAD = 2'b01,
    LVL_RAISE = 2'b10,
    LVL_DROP = 2'b11
  } lvl_op_e;

  // Next value of the level register for one bus operation.
  function automatic logic [DW-1:0] lvl_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wd,
                                             input lvl_op_e op);
    case (op)
      LVL_LOAD:  return wd;
      LVL_RAISE: return cur | wd;
      LVL_DROP:  return cur & ~wd;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/gpiobank_wake.sv
module gpiobank_wake #(
  parameter int unsigned READY_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(READY_DLY + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(READY_DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (hold)           cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CNT_TOP);

  // R2
  ready_low_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !ready_o);
  // R2
  ready_rise_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(!hold));
  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !hold) |=> ready_o);
endmodule

// File: rtl/gpiobank_sync.sv
module gpiobank_sync #(
  parameter int unsigned NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [NP-1:0] raw_i,
  output logic [NP-1:0] sense_o
);
  logic [NP-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (hold) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign sense_o = s2_q;
endmodule

// File: rtl/gpiobank_route.sv
module gpiobank_route
  import gpiobank_pkg::*;
#(
  parameter int unsigned NP = 32,
  parameter int unsigned FP = 16
) (
  input  logic [NP-1:0]   oe_i,
  input  logic [NP-1:0]   lvl_i,
  input  logic [FP-1:0]   ser_i,
  input  logic [FP-1:0]   pwm_i,
  input  logic [2*FP-1:0] src_i,
  output logic [NP-1:0]   pad_o
);
  for (genvar k = 0; k < NP; k++) begin : g_pin
    logic drv;
    if (k < FP) begin : g_sel
      pin_src_e code;
      assign code = pin_src_e'(src_i[2*k +: 2]);
      always_comb begin
        case (code)
          SRC_SER: drv = ser_i[k];
          SRC_PWM: drv = pwm_i[k];
          default: drv = lvl_i[k];
        endcase
      end
    end else begin : g_fixed
      assign drv = lvl_i[k];
    end
    assign pad_o[k] = oe_i[k] & drv;
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpiobank_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned SEL_PINS  = 16,
  parameter int unsigned READY_DLY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_hold,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [SEL_PINS-1:0] ser_tx_i,
  input  logic [SEL_PINS-1:0] pwm_i,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe
);
  localparam int unsigned SW = 2 * SEL_PINS;

  logic [NPINS-1:0] dir_q, lvl_q, sense;
  logic [SW-1:0]    src_q;
  logic             ready;
  logic             wr_accept;
  lvl_op_e          lvl_op;
  logic [DW-1:0]    lvl_nx_full;

  gpiobank_wake #(.READY_DLY(READY_DLY)) u_wake (
    .clk(clk), .rst_n(rst_n), .hold(bank_hold), .ready_o(ready)
  );

  gpiobank_sync #(.NP(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(bank_hold), .raw_i(pad_in), .sense_o(sense)
  );

  gpiobank_route #(.NP(NPINS), .FP(SEL_PINS)) u_route (
    .oe_i(dir_q), .lvl_i(lvl_q), .ser_i(ser_tx_i), .pwm_i(pwm_i),
    .src_i(src_q), .pad_o(pad_out)
  );

  assign pad_oe    = dir_q;
  assign wr_accept = bus_wr & ready & ~bank_hold;

  always_comb begin
    lvl_op = LVL_KEEP;
    if (wr_accept) begin
      case (bus_addr)
        OFS_LVL: lvl_op = LVL_LOAD;
        OFS_SET: lvl_op = LVL_RAISE;
        OFS_CLR: lvl_op = LVL_DROP;
        default: lvl_op = LVL_KEEP;
      endcase
    end
  end

  assign lvl_nx_full = lvl_next(DW'(lvl_q), bus_wdata, lvl_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      src_q <= '0;
    end else if (bank_hold) begin
      dir_q <= '0;
      lvl_q <= '0;
      src_q <= '0;
    end else begin
      lvl_q <= lvl_nx_full[NPINS-1:0];
      if (wr_accept && bus_addr == OFS_DIR) dir_q <= bus_wdata[NPINS-1:0];
      if (wr_accept && bus_addr == OFS_SRC) src_q <= bus_wdata[SW-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DIR:   bus_rdata = DW'(dir_q);
      OFS_LVL:   bus_rdata = DW'(lvl_q);
      OFS_SENSE: bus_rdata = DW'(sense);
      OFS_READY: bus_rdata = DW'(ready);
      OFS_SRC:   bus_rdata = DW'(src_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R11
  hold_clears_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hold |=> (dir_q == '0 && lvl_q == '0 && src_q == '0));
  // R1
  hold_pads_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hold |=> (pad_oe == '0));
  // R3
  idle_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_accept && !bank_hold) |=> ($stable(dir_q) && $stable(lvl_q) && $stable(src_q)));
  // R6
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_addr == OFS_SET) |=>
      (lvl_q == ($past(lvl_q) | $past(bus_wdata[NPINS-1:0]))));
  // R7
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_addr == OFS_CLR) |=>
      (lvl_q == ($past(lvl_q) & ~$past(bus_wdata[NPINS-1:0]))));
endmodule

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_hold = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ser_tx_i = 16'hA5C3;
  logic [15:0] pwm_i = 16'h3C96;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  gpio_regbank uut (
    .clk(clk), .rst_n(rst_n), .bank_hold(bank_hold), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx_i(ser_tx_i), .pwm_i(pwm_i), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Caller is at a falling edge; write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_pad(input logic [31:0] dir, input logic [31:0] lvl,
                                          input logic [31:0] src);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) begin
      logic b;
      b = lvl[k];
      if (k < 16) begin
        if (src[2*k +: 2] == 2'b00) b = ser_tx_i[k];
        else if (src[2*k +: 2] == 2'b01) b = pwm_i[k];
      end
      r[k] = dir[k] & b;
    end
    return r;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    rd(8'h00, d); check("R1 dir in hold", d, 0);
    rd(8'h04, d); check("R1 lvl in hold", d, 0);
    rd(8'h18, d); check("R1 src in hold", d, 0);
    rd(8'h14, d); check("R1 ready in hold", d, 0);
    check("R1 pad_oe in hold", pad_oe, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    bank_hold = 1'b0;
    wr(8'h00, 32'hFFFF_FFFF);           // edge 1, not ready yet
    @(negedge clk); @(negedge clk);     // edges 2, 3
    rd(8'h14, d); check("R2 ready low after 3 edges", d, 0);
    @(negedge clk);                     // edge 4
    rd(8'h14, d); check("R2 ready high after 4 edges", d, 1);
    rd(8'h00, d); check("R3 warm-up write ignored", d, 0);
  endtask

  task automatic t_dir_lvl();
    logic [31:0] d;
    wr(8'h18, 32'hAAAA_AAAA);
    wr(8'h00, 32'h0000_00FF);
    wr(8'h04, 32'h0000_0F0F);
    rd(8'h00, d); check("R4 dir readback", d, 32'h0000_00FF);
    rd(8'h04, d); check("R5 lvl readback", d, 32'h0000_0F0F);
    check("R4 pad_oe follows dir", pad_oe, 32'h0000_00FF);
    check("R5/R8 pad_out gated by dir", pad_out, 32'h0000_000F);
  endtask

  task automatic t_set_clr();
    logic [31:0] d;
    wr(8'h08, 32'h0000_3030);
    rd(8'h04, d); check("R6 set bits", d, 32'h0000_3F3F);
    rd(8'h08, d); check("R6 set reads zero", d, 0);
    wr(8'h0C, 32'h0000_0101);
    rd(8'h04, d); check("R7 clear bits", d, 32'h0000_3E3E);
    rd(8'h0C, d); check("R7 clear reads zero", d, 0);
    wr(8'h08, 32'h0);
    rd(8'h04, d); check("R6 zero set no change", d, 32'h0000_3E3E);
    check("R8 pins 8-13 masked", pad_out, 32'h0000_003E);
  endtask

  task automatic t_src();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'h1234_5678);
    wr(8'h18, 32'hE4E4_E4E4);
    rd(8'h18, d); check("R9 src readback", d, 32'hE4E4_E4E4);
    check("R9 mixed routing", pad_out, exp_pad(32'hFFFF_FFFF, 32'h1234_5678, 32'hE4E4_E4E4));
    wr(8'h18, 32'h0);
    check("R9 all serial", pad_out, exp_pad(32'hFFFF_FFFF, 32'h1234_5678, 32'h0));
    wr(8'h18, 32'h5555_5555);
    check("R9 all pwm", pad_out, exp_pad(32'hFFFF_FFFF, 32'h1234_5678, 32'h5555_5555));
  endtask

  task automatic t_input();
    logic [31:0] d;
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(8'h10, d); check("R10 one edge old value", d, 0);
    @(negedge clk);
    rd(8'h10, d); check("R10 two edges new value", d, 32'hDEAD_BEEF);
    wr(8'h10, 32'h0);
    rd(8'h10, d); check("R10 write ignored", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_rehold();
    logic [31:0] d;
    bank_hold = 1'b1;
    @(negedge clk);
    rd(8'h00, d); check("R11 dir cleared", d, 0);
    rd(8'h04, d); check("R11 lvl cleared", d, 0);
    rd(8'h18, d); check("R11 src cleared", d, 0);
    rd(8'h14, d); check("R11 ready dropped", d, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R3 write in hold ignored", d, 0);
    check("R11 pad_oe off", pad_oe, 0);
    bank_hold = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h14, d); check("R2 ready again", d, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_wake();
    t_dir_lvl();
    t_set_clr();
    t_src();
    t_input();
    t_rehold();
    finish_run();
  end
endmodule